// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a watchdog peripheral behind a small register bus. Software arms it by setting an enable bit and a reset-on-timeout bit in a mode register, and loads a reload constant into a separate register. The count does not start when the block is enabled. It starts with the first valid feed, which is two consecutive feed-register writes: the key 0xAA and then the key 0x55. Every later valid feed reloads the counter from the reload constant.

The counter runs on a watchdog tick strobe. Each tick advances a fixed divide-by-four prescaler, and every fourth tick moves the counter down by one. When the counter reaches zero, the block sets a sticky timeout flag. If reset-on-timeout is set, it also pulses a reset request for one clock. The system reset clears the flag's neighbours but not the flag itself, so that after a restart firmware can read back why the restart happened. Only a power-on reset or an explicit clear clears the flag.

Register map, selected by `bus_addr`:
- 0: mode. Bit 0 is enable, bit 1 is reset-on-timeout, bit 2 is the timeout flag.
- 1: reload constant.
- 2: feed. Writes only; reads return 0.
- 3: current count. Read only.

A cycle with `bus_sel` high is a bus access. On such a cycle, `bus_we` high makes it a write and low makes it a read. `bus_rdata` always shows the register that `bus_addr` points to, whether or not `bus_sel` is high.

Top module: `feed_watchdog`

## Requirements
- R1: While por_n and rst_n are low, and after they are released, the registers read as follows: mode reads 0, the reload constant and the count both read TC_RESET (all ones by default), and rst_req is low.
- R2: A mode write with bit 0 set sets enable, and a mode write with bit 1 set sets reset-on-timeout. Writing 0 to either bit leaves it unchanged. Only rst_n or por_n clears these two bits.
- R3: After enable is set, the count holds its value, even while ticks arrive, until the first valid feed.
- R4: A valid feed is a feed write of 0xAA followed by a feed write of 0x55 as the next bus access. Idle cycles between the two writes are allowed. A valid feed while enabled loads the count from the reload constant and clears the prescaler.
- R5: The feed sequence is broken if any other bus access comes between the two keys. This covers a read, a write to another register, or a feed write of another value. A broken sequence, a lone 0x55, or 0x55 followed by 0xAA does not reload the count. The count keeps its value.
- R6: While running, the count drops by one on every fourth tick, counting from the feed.
- R7: With reload constant T (T of 0 behaves as 1), the count reaches 0 on tick 4*max(T,1). On that same edge the flag sets, and rst_req goes high for exactly one clock if reset-on-timeout is set; otherwise rst_req stays low. The count then stays at 0.
- R8: A low pulse on rst_n leaves the timeout flag unchanged. A low pulse on por_n clears the flag. A mode write with bit 2 at 0 clears the flag. A mode write with bit 2 at 1 never sets the flag.
- R9: A write to the reload constant reads back at once but does not change the count. It takes effect at the next valid feed.
- R10: A feed sequence while the block is disabled does not load the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous; clears everything except the timeout flag |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| wd_tick | input | 1 | Watchdog tick strobe, one tick per clock while high |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| rst_req | output | 1 | One-clock reset request on timeout |

## Verification
A wrong prescaler phase shows up in the count readback within four ticks of a feed. A feed-arming state that leaks across an interrupting access shows up as an unwanted reload in the very next count read. Flag or mode bits held in the wrong reset domain show up in the mode read right after an rst_n or por_n pulse. An off-by-one in the expiry comparison moves the flag and rst_req by one tick, so a per-tick sweep over small reload values detects it on the expiry tick itself.

// File: rtl/feed_watchdog.sv
module feed_watchdog #(
  parameter int CW = 10,
  parameter int DW = 16,
  parameter int PRE_DIV = 4,
  parameter logic [CW-1:0] TC_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          wd_tick,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rst_req
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [DW-1:0] KEY_A = DW'(8'hAA);
  localparam logic [DW-1:0] KEY_B = DW'(8'h55);
  localparam logic [1:0] A_MODE = 2'd0, A_TC = 2'd1, A_FEED = 2'd2, A_CNT = 2'd3;

  logic          en, rst_en, flag, running, half;
  logic [CW-1:0] tc, cnt;
  logic [PW-1:0] pre;

  wire sys_n    = rst_n & por_n;
  wire wr       = bus_sel & bus_we;
  wire mode_wr  = wr && bus_addr == A_MODE;
  wire feed_wr  = wr && bus_addr == A_FEED;
  wire feed_ok  = feed_wr && bus_wdata == KEY_B && half && en;
  wire step     = running && wd_tick && pre == PRE_LAST;
  wire last     = cnt <= CW'(1);
  wire expire   = step && last;

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      en      <= 1'b0;
      rst_en  <= 1'b0;
      tc      <= TC_RESET;
      cnt     <= TC_RESET;
      running <= 1'b0;
      pre     <= '0;
      half    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire & rst_en;
      if (bus_sel) half <= feed_wr && bus_wdata == KEY_A;
      if (mode_wr) begin
        en     <= en | bus_wdata[0];
        rst_en <= rst_en | bus_wdata[1];
      end
      if (wr && bus_addr == A_TC) tc <= bus_wdata[CW-1:0];
      if (feed_ok) begin
        cnt     <= tc;
        pre     <= '0;
        running <= 1'b1;
      end else if (running && wd_tick) begin
        pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        if (step) begin
          cnt <= last ? '0 : cnt - 1'b1;
          if (last) running <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        flag <= 1'b0;
    else if (expire)                   flag <= 1'b1;
    else if (mode_wr && !bus_wdata[2]) flag <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {{(DW-3){1'b0}}, flag, rst_en, en};
      A_TC:    bus_rdata = DW'(tc);
      A_CNT:   bus_rdata = DW'(cnt);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/feed_watchdog_chk.sv
module feed_watchdog_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          en,
  input logic          rst_en,
  input logic          flag,
  input logic          rst_req,
  input logic          running,
  input logic          feed_ok,
  input logic [CW-1:0] cnt
);
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    en |=> en);
  p_rsten_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_en |=> rst_en);
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!running && !feed_ok) |=> $stable(cnt));
  p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !feed_ok |=> cnt <= $past(cnt));
  p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |=> !rst_req);
  p_pulse_gated_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |-> (rst_en && flag));
  p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(running) |-> cnt == '0);
  p_feed_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    feed_ok |-> en);
endmodule

bind feed_watchdog feed_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .en(en), .rst_en(rst_en),
  .flag(flag), .rst_req(rst_req), .running(running), .feed_ok(feed_ok), .cnt(cnt)
);

// File: tb/sim_feed_watchdog.sv
`timescale 1ns/1ps
module sim_feed_watchdog;
  localparam int CW = 10;
  localparam int DW = 16;
  localparam logic [DW-1:0] TCR = 16'h03FF;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, wd_tick = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic rst_req;
  int total = 0, bad = 0;
  logic [DW-1:0] v;

  always #2.5 clk = ~clk;

  feed_watchdog #(.CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wd_tick(wd_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] q);
    bus_addr = a;
    #0.5;
    q = bus_rdata;
  endtask

  task automatic ticks(input int n);
    wd_tick = 1'b1;
    repeat (n) @(negedge clk);
    wd_tick = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 16'h00AA);
    wr(2'd2, 16'h0055);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 values held during reset
    peek(2'd0, v); chk("R1 mode in reset", v, 0);
    chk("R1 rst_req in reset", rst_req, 0);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    peek(2'd0, v); chk("R1 mode", v, 0);
    peek(2'd1, v); chk("R1 tc", v, TCR);
    peek(2'd3, v); chk("R1 cnt", v, TCR);
    chk("R1 rst_req", rst_req, 0);

    // R10 feed while disabled
    wr(2'd1, 16'd5);
    feed();
    peek(2'd3, v); chk("R10 cnt untouched", v, TCR);

    // R2 and R3
    wr(2'd0, 16'h0003);
    peek(2'd0, v); chk("R2 mode set", v, 3);
    ticks(20);
    peek(2'd3, v); chk("R3 cnt holds before feed", v, TCR);

    // R4 R6 R7 sweep over reload values
    for (int t = 0; t < 10; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      wr(2'd1, DW'(t));
      feed();
      peek(2'd3, v); chk("R4 load", v, t);
      for (int k = 1; k <= 4 * eff; k++) begin
        ticks(1);
        peek(2'd3, v);
        chk("R6 count", v, (k >= 4 * eff) ? 0 : t - k / 4);
        peek(2'd0, v);
        chk("R7 flag", v[2], (k >= 4 * eff) ? 1 : 0);
        chk("R7 rst_req", rst_req, (k == 4 * eff) ? 1 : 0);
      end
      @(negedge clk);
      chk("R7 single pulse", rst_req, 0);
      ticks(8);
      peek(2'd3, v); chk("R7 stays zero", v, 0);
      chk("R7 no repeat", rst_req, 0);
      wr(2'd0, 16'h0003);
      peek(2'd0, v); chk("R8 clear by write", v, 3);
    end

    // R8 writing 1 does not set flag
    wr(2'd0, 16'h0007);
    peek(2'd0, v); chk("R8 write one no set", v, 3);
    // R2 sticky
    wr(2'd0, 16'h0000);
    peek(2'd0, v); chk("R2 sticky", v, 3);

    // R5 broken sequences
    wr(2'd1, 16'd20);
    feed();
    ticks(8);
    peek(2'd3, v); chk("R6 two steps", v, 18);
    wr(2'd2, 16'h00AA); rd(2'd0); wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R5 read breaks", v, 18);
    wr(2'd2, 16'h00AA); wr(2'd1, 16'd7); wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R5 tc write breaks", v, 18);
    peek(2'd1, v); chk("R9 tc readback", v, 7);
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h0056); wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R5 wrong key breaks", v, 18);
    wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R5 lone second key", v, 18);
    wr(2'd2, 16'h0055); wr(2'd2, 16'h00AA);
    peek(2'd3, v); chk("R5 reversed keys", v, 18);
    wr(2'd2, 16'h00AA);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R4 R9 idle gap feed loads new tc", v, 7);
    ticks(4);
    peek(2'd3, v); chk("R6 one step", v, 6);
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h00AA); wr(2'd2, 16'h0055);
    peek(2'd3, v); chk("R4 repeated first key", v, 7);

    // R8 flag across system reset, R7 gating
    wr(2'd1, 16'd1);
    feed();
    ticks(4);
    chk("R7 pulse with reset enabled", rst_req, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd0, v); chk("R8 flag kept over rst_n", v, 4);
    peek(2'd1, v); chk("R1 tc after rst_n", v, TCR);
    wr(2'd0, 16'h0005);
    peek(2'd0, v); chk("R2 enable only", v, 5);
    wr(2'd1, 16'd2);
    feed();
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      chk("R7 no pulse without reset enable", rst_req, 0);
    end
    peek(2'd3, v); chk("R7 expired without reset", v, 0);
    peek(2'd0, v); chk("R7 flag set", v, 5);
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    peek(2'd0, v); chk("R8 por clears flag", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule